// File: doc/BRIEF.md
# Low Memory Remap Translator

This block turns a 4 KiB page number into the physical page number that actually holds the data when the top of the 32-bit address space is carved out as a hole. Software programs three 16-bit configuration values: the top of low memory, the base of the remap window, and the limit of that window. Each value is scaled into page units inside the block. A page below the top of low memory is returned as it came in. A page at or above the 4 GiB line (page 0x100000) and below the remap base is also returned as it came in. Every other page is moved by the distance between the remap base and the top of low memory.

A moved page is legal only if it lands strictly below the remap limit. An illegal result is replaced by the last page under the top of low memory, and an out-of-range flag is raised with it. Translation requests arrive with a valid strobe. The result leaves a single register stage one cycle later. Decoding of the hole on the system bus is not part of this block.

Top module: `lomem_remap_xlat`

## Requirements
- R1: After reset `out_valid` is 0 and all three configuration values are zero. Any page translated before programming is therefore flagged, with `out_oor`=1 and `out_page`=0xFFFFFFFF.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` into the value chosen by `cfg_sel`: 0 selects top of low memory, 1 selects remap base, 2 selects remap limit. The new value applies to requests accepted in later cycles. A request accepted in the same cycle as the write still sees the old value.
- R3: Top of low memory is scaled to pages by a left shift of 4. Remap base and remap limit are each scaled by a left shift of 14. All three become 32-bit page values.
- R4: A page strictly below the scaled top of low memory is returned unchanged with `out_oor`=0.
- R5: A page at or above 0x100000 and strictly below the scaled remap base is returned unchanged with `out_oor`=0.
- R6: Any other page is translated to page − top + base. This sum is computed without wrapping at 32 bits. When it is strictly below the scaled limit, it is returned with `out_oor`=0.
- R7: When the sum from R6 is not below the scaled limit, `out_page` is (scaled top − 1) modulo 2^32 and `out_oor`=1.
- R8: `out_valid` equals `in_valid` from the previous cycle. In a cycle after `in_valid`=0, `out_page` and `out_oor` keep their previous values.
- R9: A write with `cfg_sel`=3 changes none of the three values, so later translations are the same as without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Selects the value to write: 0 top, 1 base, 2 limit, 3 none |
| cfg_wdata | input | 16 | Raw configuration value |
| in_valid | input | 1 | Translation request strobe |
| in_page | input | 32 | Page number to translate |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_page | output | 32 | Translated or clamped page |
| out_oor | output | 1 | Result was out of range and clamped |

## Verification
The clamp property only holds when the top-of-low value is not rewritten in the same cycle as the request it checks. It therefore excludes that case. The bench does drive that case on purpose, and checks it against its own model rather than the property. The pass-through properties compare against the scaled values held in the configuration stage at the moment of the request. The stimulus mixes random programming, including the unused selector, with pages aimed at each boundary ±1, page 0x100000 and the all-ones page. Together these reach every translation region and the overflow of the 32-bit sum.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic [1:0] {
    CSEL_TOP   = 2'd0,
    CSEL_BASE  = 2'd1,
    CSEL_LIMIT = 2'd2,
    CSEL_SPARE = 2'd3
  } cfg_sel_e;

  localparam int unsigned NUM_CFG = 3;
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
  import remap_pkg::*;
#(
  parameter int unsigned REG_W     = 16,
  parameter int unsigned PAGE_W    = 32,
  parameter int unsigned TOP_SHIFT = 4,
  parameter int unsigned WIN_SHIFT = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [PAGE_W-1:0] top_pg,
  output logic [PAGE_W-1:0] base_pg,
  output logic [PAGE_W-1:0] limit_pg
);

  logic [NUM_CFG-1:0][REG_W-1:0] raw;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_reg
    localparam logic [1:0] MY_SEL = 2'(g);
    logic [REG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                            q <= '0;
      else if (cfg_we && cfg_sel == MY_SEL) q <= cfg_wdata;
    end
    assign raw[g] = q;
  end

  assign top_pg   = PAGE_W'(raw[CSEL_TOP])   << TOP_SHIFT;
  assign base_pg  = PAGE_W'(raw[CSEL_BASE])  << WIN_SHIFT;
  assign limit_pg = PAGE_W'(raw[CSEL_LIMIT]) << WIN_SHIFT;

  AST_SPARE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == CSEL_SPARE) |=> $stable(raw)); // R9

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(raw)); // R2

endmodule

// File: rtl/remap_calc.sv
module remap_calc #(
  parameter int unsigned     PAGE_W    = 32,
  parameter longint unsigned HIGH_PAGE = 64'h10_0000
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] top_pg,
  input  logic [PAGE_W-1:0] base_pg,
  input  logic [PAGE_W-1:0] limit_pg,
  output logic [PAGE_W-1:0] res_page,
  output logic              res_oor
);

  localparam int unsigned       EXT_W  = PAGE_W + 1;
  localparam logic [PAGE_W-1:0] HIGH_P = PAGE_W'(HIGH_PAGE);

  logic             below_top;
  logic             high_pass;
  logic             fits;
  logic [EXT_W-1:0] moved;

  assign below_top = page < top_pg;
  assign high_pass = (page >= HIGH_P) && (page < base_pg);
  assign moved     = {1'b0, page} - {1'b0, top_pg} + {1'b0, base_pg};
  assign fits      = moved < {1'b0, limit_pg};

  always_comb begin
    if (below_top || high_pass) begin
      res_page = page;
      res_oor  = 1'b0;
    end else if (fits) begin
      res_page = moved[PAGE_W-1:0];
      res_oor  = 1'b0;
    end else begin
      res_page = top_pg - PAGE_W'(1);
      res_oor  = 1'b1;
    end
  end

endmodule

// File: rtl/remap_out_stage.sv
module remap_out_stage #(
  parameter int unsigned PAGE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [PAGE_W-1:0] res_page,
  input  logic              res_oor,
  output logic              out_valid,
  output logic [PAGE_W-1:0] out_page,
  output logic              out_oor
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_page  <= '0;
      out_oor   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_page <= res_page;
        out_oor  <= res_oor;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R8

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_page) && $stable(out_oor))); // R8

endmodule

// File: rtl/lomem_remap_xlat.sv
module lomem_remap_xlat
  import remap_pkg::*;
#(
  parameter int unsigned     REG_W     = 16,
  parameter int unsigned     PAGE_W    = 32,
  parameter int unsigned     TOP_SHIFT = 4,
  parameter int unsigned     WIN_SHIFT = 14,
  parameter longint unsigned HIGH_PAGE = 64'h10_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              in_valid,
  input  logic [PAGE_W-1:0] in_page,
  output logic              out_valid,
  output logic [PAGE_W-1:0] out_page,
  output logic              out_oor
);

  localparam logic [PAGE_W-1:0] HIGH_P = PAGE_W'(HIGH_PAGE);

  logic [PAGE_W-1:0] top_pg;
  logic [PAGE_W-1:0] base_pg;
  logic [PAGE_W-1:0] limit_pg;
  logic [PAGE_W-1:0] res_page;
  logic              res_oor;

  remap_cfg_regs #(
    .REG_W(REG_W), .PAGE_W(PAGE_W), .TOP_SHIFT(TOP_SHIFT), .WIN_SHIFT(WIN_SHIFT)
  ) i_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .top_pg(top_pg), .base_pg(base_pg), .limit_pg(limit_pg)
  );

  remap_calc #(
    .PAGE_W(PAGE_W), .HIGH_PAGE(HIGH_PAGE)
  ) i_calc (
    .page(in_page), .top_pg(top_pg), .base_pg(base_pg), .limit_pg(limit_pg),
    .res_page(res_page), .res_oor(res_oor)
  );

  remap_out_stage #(
    .PAGE_W(PAGE_W)
  ) i_out (
    .clk(clk), .rst(rst), .in_valid(in_valid), .res_page(res_page), .res_oor(res_oor),
    .out_valid(out_valid), .out_page(out_page), .out_oor(out_oor)
  );

  AST_LOW_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_page < top_pg) |=> (out_page == $past(in_page) && !out_oor)); // R4

  AST_HIGH_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_page >= HIGH_P && in_page < base_pg)
      |=> (out_page == $past(in_page) && !out_oor)); // R5

  AST_CLAMP_VALUE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(cfg_we && cfg_sel == CSEL_TOP))
      |=> (!out_oor || out_page == top_pg - PAGE_W'(1))); // R7

endmodule

// File: tb/test_lomem_remap_xlat.sv
module test_lomem_remap_xlat;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        in_valid = 1'b0;
  logic [31:0] in_page = 32'd0;
  logic        out_valid;
  logic [31:0] out_page;
  logic        out_oor;

  int vectors = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lomem_remap_xlat i_lomem_remap_xlat (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_page(in_page),
    .out_valid(out_valid), .out_page(out_page), .out_oor(out_oor)
  );

  // Behavioural reference: raw values mirrored as integers
  longint m_top = 0, m_base = 0, m_lim = 0;
  bit     e_valid = 1'b0;
  longint e_page = 0;
  bit     e_oor = 1'b0;
  int     e_req = 0;

  function automatic void ref_xlate(input longint pg, input longint t, input longint b,
                                    input longint l, output longint rp, output bit ro,
                                    output int rq);
    longint tp = t * 16;
    longint bp = b * 16384;
    longint lp = l * 16384;
    longint mv;
    if (pg < tp) begin rp = pg; ro = 0; rq = 4; end
    else if (pg >= 64'h10_0000 && pg < bp) begin rp = pg; ro = 0; rq = 5; end
    else begin
      mv = pg - tp + bp;
      if (mv < lp) begin rp = mv; ro = 0; rq = 6; end
      else begin rp = (tp - 1) & 64'hFFFF_FFFF; ro = 1; rq = 7; end
    end
  endfunction

  always @(posedge clk) begin
    longint rp; bit ro; int rq;
    if (rst) begin
      m_top <= 0; m_base <= 0; m_lim <= 0; e_valid <= 1'b0;
    end else begin
      e_valid <= in_valid;
      if (in_valid) begin
        ref_xlate(longint'(in_page), m_top, m_base, m_lim, rp, ro, rq);
        e_page <= rp; e_oor <= ro; e_req <= rq;
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_top  <= longint'(cfg_wdata);
          2'd1: m_base <= longint'(cfg_wdata);
          2'd2: m_lim  <= longint'(cfg_wdata);
          default: ;
        endcase
      end
    end
  end

  // Cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      vectors++;
      if (out_valid !== e_valid) begin
        errors++;
        $display("FAIL R8 out_valid actual=%0b expected=%0b", out_valid, e_valid);
      end else if (e_valid && (longint'(out_page) != e_page || out_oor !== e_oor)) begin
        errors++;
        $display("FAIL R%0d page actual=%h/%0b expected=%h/%0b",
                 e_req, out_page, out_oor, e_page, e_oor);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] ap, input logic ao,
                       input logic [31:0] xp, input logic xo);
    vectors++;
    if (ap !== xp || ao !== xo) begin
      errors++;
      $display("FAIL %s actual=%h/%0b expected=%h/%0b", req, ap, ao, xp, xo);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic xlate(input string req, input logic [31:0] pg,
                       input logic [31:0] xp, input logic xo);
    @(negedge clk); in_valid = 1'b1; in_page = pg;
    @(negedge clk); in_valid = 1'b0;
    check(req, out_page, out_oor, xp, xo);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'd0, out_valid, 32'd0, 1'b0);
    rst = 1'b0;
    xlate("R1 unprogrammed", 32'h0001_2345, 32'hFFFF_FFFF, 1'b1);
    xlate("R1 page zero", 32'h0, 32'hFFFF_FFFF, 1'b1);

    cfg_write(2'd0, 16'hC000);  // top  -> 0xC0000
    cfg_write(2'd1, 16'h0044);  // base -> 0x110000
    cfg_write(2'd2, 16'h0048);  // limit-> 0x120000
    xlate("R3 R4 below top", 32'h000B_FFFF, 32'h000B_FFFF, 1'b0);
    xlate("R4 zero", 32'h0, 32'h0, 1'b0);
    xlate("R3 R6 top page", 32'h000C_0000, 32'h0011_0000, 1'b0);
    xlate("R6 last fit", 32'h000C_FFFF, 32'h0011_FFFF, 1'b0);
    xlate("R7 at limit", 32'h000D_0000, 32'h000B_FFFF, 1'b1);
    xlate("R5 4GiB line", 32'h0010_0000, 32'h0010_0000, 1'b0);
    xlate("R3 R5 below base", 32'h0010_FFFF, 32'h0010_FFFF, 1'b0);
    xlate("R7 at base", 32'h0011_0000, 32'h000B_FFFF, 1'b1);
    xlate("R6 R7 no wrap", 32'hFFFF_FFFF, 32'h000B_FFFF, 1'b1);

    // same-cycle write and request
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 16'hD000;
    in_valid = 1'b1; in_page = 32'h000C_8000;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    check("R2 old value same cycle", out_page, out_oor, 32'h0011_8000, 1'b0);
    xlate("R2 new value later", 32'h000C_8000, 32'h000C_8000, 1'b0);
    cfg_write(2'd0, 16'hC000);

    cfg_write(2'd3, 16'h0000);
    xlate("R9 spare select", 32'h000C_0000, 32'h0011_0000, 1'b0);

    // hold when idle
    @(negedge clk);
    check("R8 idle valid", 32'd0, out_valid, 32'd0, 1'b0);
    check("R8 idle hold", out_page, out_oor, 32'h0011_0000, 1'b0);

    // random mixed traffic, model compared on every clock
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      cfg_we = ($urandom_range(0, 9) == 0);
      cfg_sel = 2'($urandom_range(0, 3));
      cfg_wdata = (cfg_sel == 2'd0) ? 16'($urandom_range(16'h4000, 16'hFFFF))
                                    : 16'($urandom_range(16'h0040, 16'h00A0));
      in_valid = ($urandom_range(0, 3) != 0);
      case ($urandom_range(0, 6))
        0: in_page = 32'(m_top * 16 + $urandom_range(0, 2) - 1);
        1: in_page = 32'(m_base * 16384 + $urandom_range(0, 2) - 1);
        2: in_page = 32'h0010_0000 - 32'($urandom_range(0, 1));
        3: in_page = 32'hFFFF_FFFF;
        4: in_page = 32'($urandom_range(0, 32'h0030_0000));
        default: in_page = $urandom;
      endcase
    end
    @(negedge clk); cfg_we = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule